// File: doc/BRIEF.md
# ATA Taskfile Command Issuer

This block turns a sector read or write request into the series of register writes that starts the command on an ATA device. A request carries a 48-bit starting block address, a 16-bit sector count, a direction, a transfer-mode choice (programmed I/O or DMA) and a flag that picks device 1 instead of device 0. The block decides whether the command needs the 48-bit extended form. It waits for the device to drop its busy flag and writes the device/head register. If that write moved the selection to the other device, it waits a settle interval and polls busy again. It then writes the parameter bytes and finally the command byte.

All writes leave through an 8-bit write port with a 3-bit register address. The device status byte is presented on an input, and bit 7 of it is the busy flag. A free-running tick input (one pulse per 100 ns by default) times both the settle interval and the give-up limit on every busy wait. The block ends each request with either a one-cycle completion pulse or a one-cycle timeout pulse. The data phase, bus timing and interrupts belong to other logic.

Top module: `tf_cmd_issuer`

## Requirements
- R1: `req_ready` is high only when the block is idle. A request is taken only while `req_ready` is high, and `req_valid` pulses while a request is in progress leave the write stream unchanged.
- R2: The extended (48-bit) form is used when the sector count is at least 256, or when the starting address plus the count is at least 2^28. Every other request uses the 28-bit form.
- R3: In the extended form, ten parameter writes follow the device/head write. The first five go to addresses 1..5 carrying 0x00, count[15:8], lba[31:24], lba[39:32] and lba[47:40]. The next five go to addresses 1..5 carrying 0x00, count[7:0], lba[7:0], lba[15:8] and lba[23:16]. The command byte is then written to address 7.
- R4: In the 28-bit form, exactly five parameter writes follow the device/head write: addresses 1..5 carrying 0x00, count[7:0], lba[7:0], lba[15:8] and lba[23:16]. The command byte is then written to address 7. Every request writes the device/head register (address 6) before any other register and the command register last, in consecutive cycles.
- R5: The device/head byte has bit 7 = 0, bit 6 = 1 (block addressing), bit 5 = 0, bit 4 = device-1 flag, and bits 3:0 = lba[27:24] in the 28-bit form or 0 in the extended form.
- R6: The command byte is 0x20 for a read with programmed I/O, 0x30 for a write with programmed I/O, 0xC8 for a DMA read and 0xCA for a DMA write. The extended forms are 0x24, 0x34, 0x25 and 0x35 respectively. Every extended code satisfies (code & ~0x11) == 0x24.
- R7: No register write happens while status bit 7 (busy) is set. The device/head write comes only after busy was seen clear.
- R8: If the device-1 flag differs from the last device selected (device 0 after reset), the block waits at least SETTLE_TICKS ticks after the device/head write and then polls busy again before the next write. Otherwise the next write follows in the very next cycle.
- R9: A busy wait that lasts TIMEOUT_TICKS ticks ends the request with a one-cycle `timeout` pulse. No further register writes follow, and the block returns to idle.
- R10: `done` pulses for exactly one cycle, in the cycle right after the command-register write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_write | input | 1 | 1 = write to the device, 0 = read |
| req_dma | input | 1 | 1 = DMA command, 0 = programmed I/O command |
| req_dev1 | input | 1 | 1 = target device 1, 0 = device 0 |
| req_lba | input | 48 | Starting block address |
| req_count | input | 16 | Sector count |
| req_ready | output | 1 | Block is idle and accepts a request |
| stat_in | input | 8 | Device status byte, bit 7 = busy |
| tick | input | 1 | Time-base pulse (100 ns per pulse by default) |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 3 | Register address (1..5 parameters, 6 device/head, 7 command) |
| wr_data | output | 8 | Register write data |
| done | output | 1 | One-cycle pulse after the command write |
| timeout | output | 1 | One-cycle pulse when a busy wait gives up |

## Verification
The main function is tried with small addresses and counts that stay in the 28-bit form, and with counts of exactly 256 and 255, which show whether the count test is placed correctly. Address-plus-count sums of exactly 2^28 and 2^28 - 1 show whether the address test has an off-by-one error. A large address with a large count checks that bytes come out in high-then-low order and that the device/head byte has zero in bits 3:0. Each of the four direction/mode pairs shows whether the right command code is chosen. Alternating the device flag separates the settle-and-repoll path from the direct path, and holding busy before selection, after selection, or indefinitely covers the wait, the re-poll and the timeout exit.

// File: rtl/tf_pkg.sv
`timescale 1ns/1ps
package tf_pkg;
  localparam int LBA_W      = 48;
  localparam int CNT_W      = 16;
  localparam int SHORT_W    = 28;   // address bits reachable by the 28-bit form
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 3;
  localparam int IDX_W      = 4;
  localparam int FRAME_LAST = 10;   // index of the command byte
  localparam int SHORT_START = 5;   // first index used by the 28-bit form
  localparam int BSY_BIT    = 7;

  localparam logic [ADDR_W-1:0] RA_DEV = 3'd6;
  localparam logic [ADDR_W-1:0] RA_CMD = 3'd7;

  localparam logic [BYTE_W-1:0] OP_RD_PIO  = 8'h20;
  localparam logic [BYTE_W-1:0] OP_WR_PIO  = 8'h30;
  localparam logic [BYTE_W-1:0] OP_RD_DMA  = 8'hC8;
  localparam logic [BYTE_W-1:0] OP_WR_DMA  = 8'hCA;
  localparam logic [BYTE_W-1:0] OP_RD_PIOX = 8'h24;
  localparam logic [BYTE_W-1:0] OP_WR_PIOX = 8'h34;
  localparam logic [BYTE_W-1:0] OP_RD_DMAX = 8'h25;
  localparam logic [BYTE_W-1:0] OP_WR_DMAX = 8'h35;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_A, ST_SELECT, ST_SETTLE,
    ST_WAIT_B, ST_SEND, ST_FIN_OK, ST_FIN_TO
  } iss_state_e;
endpackage

// File: rtl/tf_tick_timer.sv
`timescale 1ns/1ps
module tf_tick_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expired = (cnt_q >= W'(LIMIT));
  assign cnt_en  = clr | (tick & ~expired);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9 / R8: the tick count never runs past its limit
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= W'(LIMIT));
endmodule

// File: rtl/tf_frame_build.sv
`timescale 1ns/1ps
module tf_frame_build
  import tf_pkg::*;
(
  input  logic [LBA_W-1:0]  lba_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              write_i,
  input  logic              dma_i,
  input  logic              dev1_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              ext_o,
  output logic [BYTE_W-1:0] dev_byte_o,
  output logic [ADDR_W-1:0] byte_addr_o,
  output logic [BYTE_W-1:0] byte_data_o
);
  localparam int SUM_W = LBA_W + 1;

  logic [SUM_W-1:0]  end_addr;
  logic [BYTE_W-1:0] cmd_code;

  assign end_addr = {1'b0, lba_i} + SUM_W'(cnt_i);
  assign ext_o    = (|cnt_i[CNT_W-1:BYTE_W]) | (|end_addr[SUM_W-1:SHORT_W]);

  assign dev_byte_o = {1'b0, 1'b1, 1'b0, dev1_i,
                       ext_o ? 4'h0 : lba_i[SHORT_W-1:24]};

  always_comb begin
    unique case ({dma_i, write_i})
      2'b00:   cmd_code = ext_o ? OP_RD_PIOX : OP_RD_PIO;
      2'b01:   cmd_code = ext_o ? OP_WR_PIOX : OP_WR_PIO;
      2'b10:   cmd_code = ext_o ? OP_RD_DMAX : OP_RD_DMA;
      default: cmd_code = ext_o ? OP_WR_DMAX : OP_WR_DMA;
    endcase
  end

  always_comb begin
    if (idx_i < IDX_W'(SHORT_START))
      byte_addr_o = ADDR_W'(idx_i + IDX_W'(1));
    else if (idx_i < IDX_W'(FRAME_LAST))
      byte_addr_o = ADDR_W'(idx_i - IDX_W'(SHORT_START - 1));
    else
      byte_addr_o = RA_CMD;

    unique case (idx_i)
      4'd1:    byte_data_o = cnt_i[15:8];
      4'd2:    byte_data_o = lba_i[31:24];
      4'd3:    byte_data_o = lba_i[39:32];
      4'd4:    byte_data_o = lba_i[47:40];
      4'd6:    byte_data_o = cnt_i[7:0];
      4'd7:    byte_data_o = lba_i[7:0];
      4'd8:    byte_data_o = lba_i[15:8];
      4'd9:    byte_data_o = lba_i[23:16];
      4'd10:   byte_data_o = cmd_code;
      default: byte_data_o = '0;   // feature bytes
    endcase
  end
endmodule

// File: rtl/tf_cmd_issuer.sv
`timescale 1ns/1ps
module tf_cmd_issuer
  import tf_pkg::*;
#(
  parameter int SETTLE_TICKS  = 4,
  parameter int TIMEOUT_TICKS = 320_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dma,
  input  logic              req_dev1,
  input  logic [LBA_W-1:0]  req_lba,
  input  logic [CNT_W-1:0]  req_count,
  output logic              req_ready,
  input  logic [BYTE_W-1:0] stat_in,
  input  logic              tick,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              done,
  output logic              timeout
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  iss_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              cur_dev_q, cur_dev_d;
  logic [LBA_W-1:0]  lba_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              write_q, dma_q, dev1_q;
  logic              load_req, idx_en, dev_en;
  logic              busy, to_exp, st_exp, to_clr, st_clr;
  logic              fb_ext;
  logic [BYTE_W-1:0] fb_dev, fb_data;
  logic [ADDR_W-1:0] fb_addr;

  assign busy = stat_in[BSY_BIT];

  tf_frame_build u_frame (
    .lba_i(lba_q), .cnt_i(cnt_q), .write_i(write_q), .dma_i(dma_q),
    .dev1_i(dev1_q), .idx_i(idx_q), .ext_o(fb_ext), .dev_byte_o(fb_dev),
    .byte_addr_o(fb_addr), .byte_data_o(fb_data)
  );

  assign to_clr = (state_q != ST_WAIT_A) && (state_q != ST_WAIT_B);
  assign st_clr = (state_q != ST_SETTLE);

  tf_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_give_up (
    .clk(clk), .rst_n(rst_int_n), .clr(to_clr), .tick(tick), .expired(to_exp)
  );
  tf_tick_timer #(.LIMIT(SETTLE_TICKS)) u_settle (
    .clk(clk), .rst_n(rst_int_n), .clr(st_clr), .tick(tick), .expired(st_exp)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    cur_dev_d = cur_dev_q;
    load_req  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (req_valid) begin
                   load_req = 1'b1;
                   state_d  = ST_WAIT_A;
                 end
      ST_WAIT_A: if (!busy)      state_d = ST_SELECT;
                 else if (to_exp) state_d = ST_FIN_TO;
      ST_SELECT: begin
                   cur_dev_d = dev1_q;
                   idx_d     = fb_ext ? '0 : IDX_W'(SHORT_START);
                   state_d   = (dev1_q != cur_dev_q) ? ST_SETTLE : ST_SEND;
                 end
      ST_SETTLE: if (st_exp) state_d = ST_WAIT_B;
      ST_WAIT_B: if (!busy)      state_d = ST_SEND;
                 else if (to_exp) state_d = ST_FIN_TO;
      ST_SEND:   if (idx_q == IDX_W'(FRAME_LAST)) state_d = ST_FIN_OK;
                 else idx_d = idx_q + IDX_W'(1);
      default:   state_d = ST_IDLE;   // both finish states
    endcase
  end

  assign idx_en = (state_q == ST_SELECT) || (state_q == ST_SEND);
  assign dev_en = (state_q == ST_SELECT);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      cur_dev_q <= 1'b0;
      lba_q     <= '0;
      cnt_q     <= '0;
      write_q   <= 1'b0;
      dma_q     <= 1'b0;
      dev1_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q     <= idx_d;
      if (dev_en) cur_dev_q <= cur_dev_d;
      if (load_req) begin
        lba_q   <= req_lba;
        cnt_q   <= req_count;
        write_q <= req_write;
        dma_q   <= req_dma;
        dev1_q  <= req_dev1;
      end
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign wr_en     = (state_q == ST_SELECT) || (state_q == ST_SEND);
  assign wr_addr   = (state_q == ST_SELECT) ? RA_DEV : fb_addr;
  assign wr_data   = (state_q == ST_SELECT) ? fb_dev : fb_data;
  assign done      = (state_q == ST_FIN_OK);
  assign timeout   = (state_q == ST_FIN_TO);

  a_r1_no_ready_while_writing: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_en |-> !req_ready);
  a_r4_cmd_ends_burst: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_addr == RA_CMD) |=> !wr_en);
  a_r5_ext_dev_low_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_addr == RA_DEV && fb_ext) |-> (wr_data[3:0] == 4'h0));
  a_r6_ext_code_form: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_addr == RA_CMD && fb_ext) |-> ((wr_data & ~8'h11) == 8'h24));
  a_r7_select_after_idle_bsy: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_addr == RA_DEV) |-> !$past(stat_in[BSY_BIT]));
  a_r8_settle_after_select: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(state_q == ST_SETTLE) |-> $past(wr_en && wr_addr == RA_DEV));
  a_r10_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> $past(wr_en && wr_addr == RA_CMD));
  a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);
endmodule

// File: tb/tb_tf_cmd_issuer.sv
`timescale 1ns/1ps
module tb_tf_cmd_issuer;
  localparam int SETTLE  = 4;
  localparam int GIVE_UP = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_dma = 1'b0, req_dev1 = 1'b0;
  logic [47:0] req_lba = '0;
  logic [15:0] req_count = '0;
  logic        req_ready;
  logic        stat_busy = 1'b0;
  logic [7:0]  stat_in;
  logic        tick = 1'b0;
  logic        wr_en, done, timeout;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;

  assign stat_in = stat_busy ? 8'hD0 : 8'h50;

  tf_cmd_issuer #(.SETTLE_TICKS(SETTLE), .TIMEOUT_TICKS(GIVE_UP)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dma(req_dma), .req_dev1(req_dev1), .req_lba(req_lba),
    .req_count(req_count), .req_ready(req_ready), .stat_in(stat_in),
    .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .timeout(timeout)
  );

  always #2.5 clk = ~clk;   // 200 MHz

  int tests = 0, fails = 0;
  bit finished = 1'b0;
  int tick_total = 0;
  int cyc = 0;

  // scoreboard item: [12:11] kind (0 write, 1 done, 2 timeout), [10:8] addr, [7:0] data
  logic [12:0] exp_q[$];
  bit  model_dev = 1'b0;
  bit  exp_settle = 1'b0;
  bit  cur_ext = 1'b0;
  bit  gap_pending = 1'b0;
  int  dev_cyc = 0, dev_tick = 0;
  bit  prev_cmd = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1 tick = ~tick;
      if (tick) tick_total++;
    end
  end

  // monitor: pops expected items as the design produces them
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (wr_en) begin
        logic [12:0] it;
        string tag;
        tag = (wr_addr == 3'd6) ? "R5" : (wr_addr == 3'd7) ? "R6" : (cur_ext ? "R2/R3" : "R2/R4");
        if (exp_q.size() == 0) chk(1'b0, "R1 unexpected write", {19'd0, wr_addr, wr_data}, 0);
        else begin
          it = exp_q.pop_front();
          chk(it == {2'd0, wr_addr, wr_data}, tag, {19'd0, wr_addr, wr_data}, {19'd0, it});
        end
        if (stat_in[7]) chk(1'b0, "R7 write while busy", 1, 0);
        if (gap_pending) begin
          gap_pending = 1'b0;
          if (exp_settle)
            chk(((tick_total - dev_tick) >= SETTLE) && (cyc - dev_cyc > 1), "R8 settle",
                tick_total - dev_tick, SETTLE);
          else
            chk(cyc - dev_cyc == 1, "R8 no settle", cyc - dev_cyc, 1);
        end
        if (wr_addr == 3'd6) begin
          gap_pending = 1'b1; dev_cyc = cyc; dev_tick = tick_total;
        end
      end
      if (prev_cmd || done) chk(done == prev_cmd, "R10 done timing", done, prev_cmd);
      if (done) begin
        logic [12:0] it;
        if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
        else begin it = exp_q.pop_front(); chk(it == 13'h0800, "R10 done", it, 13'h0800); end
      end
      if (timeout) begin
        logic [12:0] it;
        if (exp_q.size() == 0) chk(1'b0, "R9 unexpected timeout", 1, 0);
        else begin it = exp_q.pop_front(); chk(it == 13'h1000, "R9 timeout", it, 13'h1000); end
      end
      prev_cmd = wr_en && (wr_addr == 3'd7);
    end
  end

  function automatic logic [7:0] cmd_of(bit w, bit d, bit e);
    case ({d, w})
      2'b00:   return e ? 8'h24 : 8'h20;
      2'b01:   return e ? 8'h34 : 8'h30;
      2'b10:   return e ? 8'h25 : 8'hC8;
      default: return e ? 8'h35 : 8'hCA;
    endcase
  endfunction

  task automatic push_w(input logic [2:0] a, input logic [7:0] d);
    exp_q.push_back({2'd0, a, d});
  endtask

  task automatic run_op(input logic [47:0] lba, input logic [15:0] cnt, input bit w,
                        input bit d, input bit dev, input int pre_busy,
                        input int post_busy, input bit give_up);
    logic [48:0] sum;
    bit e;
    sum = {1'b0, lba} + {33'd0, cnt};
    e = (cnt >= 16'd256) || (sum >= 49'h1000_0000);
    if (give_up) begin
      exp_q.push_back(13'h1000);
    end else begin
      cur_ext = e;
      exp_settle = (dev != model_dev);
      model_dev = dev;
      push_w(3'd6, {1'b0, 1'b1, 1'b0, dev, e ? 4'h0 : lba[27:24]});
      if (e) begin
        push_w(3'd1, 8'h00); push_w(3'd2, cnt[15:8]); push_w(3'd3, lba[31:24]);
        push_w(3'd4, lba[39:32]); push_w(3'd5, lba[47:40]);
      end
      push_w(3'd1, 8'h00); push_w(3'd2, cnt[7:0]); push_w(3'd3, lba[7:0]);
      push_w(3'd4, lba[15:8]); push_w(3'd5, lba[23:16]);
      push_w(3'd7, cmd_of(w, d, e));
      exp_q.push_back(13'h0800);
    end
    stat_busy = (pre_busy > 0) || give_up;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_lba = lba; req_count = cnt; req_write = w; req_dma = d; req_dev1 = dev;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 ready low in progress", req_ready, 0);
    if (pre_busy > 0) begin
      // a stray request while busy must be ignored (R1)
      req_lba = 48'hFFFF_FFFF_FFFF; req_count = 16'hFFFF; req_dev1 = ~dev;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (pre_busy) @(negedge clk);
      stat_busy = 1'b0;
    end
    if (post_busy > 0) begin
      while (!(wr_en && wr_addr == 3'd6)) @(negedge clk);
      #1 stat_busy = 1'b1;
      repeat (post_busy) @(negedge clk);
      stat_busy = 1'b0;
    end
    while (!(done || timeout)) @(negedge clk);
    stat_busy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    chk(wr_en == 1'b0, "R1 reset no write", wr_en, 0);
    chk(done == 1'b0 && timeout == 1'b0, "R10 reset no pulse", {done, timeout}, 0);

    run_op(48'h0000_0012_3456, 16'd8,     1'b0, 1'b0, 1'b0, 0, 0, 1'b0); // R4 read pio
    run_op(48'h0000_0ABC_DEF0, 16'd255,   1'b1, 1'b1, 1'b0, 12, 0, 1'b0); // R2 count 255, R7 wait
    run_op(48'h0000_0000_0010, 16'h0100,  1'b0, 1'b1, 1'b1, 0, 20, 1'b0); // R2 count 256, R8 change
    run_op(48'h0000_0FFF_FFF0, 16'h0010,  1'b1, 1'b0, 1'b1, 0, 0, 1'b0); // R2 sum = 2^28
    run_op(48'h0000_0FFF_FFEF, 16'h0010,  1'b0, 1'b0, 1'b1, 0, 0, 1'b0); // R2 sum = 2^28-1
    run_op(48'hABCD_EF01_2345, 16'h1234,  1'b0, 1'b0, 1'b0, 0, 0, 1'b0); // R3 high-then-low
    run_op(48'h0000_0000_0777, 16'd2,     1'b1, 1'b0, 1'b1, 0, 0, 1'b1); // R9 timeout
    run_op(48'h0000_0000_0042, 16'd1,     1'b1, 1'b1, 1'b0, 3, 0, 1'b0); // R9 idle again
    run_op(48'h0000_0100_0000, 16'd300,   1'b1, 1'b1, 1'b1, 0, 0, 1'b0); // R6 write dma ext

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
    chk(req_ready == 1'b1, "R9 back to idle", req_ready, 1);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule